// File: doc/BRIEF.md
# Virtual Pointer Allocation Table

A memory wrapper placed between a processor-side request port and a single-port backing RAM. Software allocates regions by size and element type and gets back a virtual pointer. It then reads and writes through any address inside a region, and finally frees the region. The block keeps a small table of live regions. Each row holds the virtual base, the physical base, the element type, the size, a reservation flag and the identity of the requester that set the flag. The block translates every access into a physical RAM address. Physical bases come from an external address source over a request/grant pair.

Virtual pointers are never reused. Each new pointer is the previous pointer plus the size of the previous allocation. A running total of allocated words is checked against a configured limit. Lookups scan the table one row per clock. A free closes the gap it leaves by moving later rows down one per clock. Three programmable delay inputs set the response latency of allocations, of data accesses, and of control operations (free, reserve, release).

The control is one state machine with eight states:
- IDLE accepts a request when `busy` is low.
- GRANT waits for the address source.
- SEARCH scans the table.
- RAM issues the RAM cycle.
- RAMWAIT captures read data.
- COMPACT moves rows.
- DELAY runs the latency counter.
- RESP pulses the response.

Transitions:
- IDLE→GRANT on an allocation that fits.
- IDLE→DELAY on an intake error.
- IDLE→SEARCH on any table operation.
- GRANT→DELAY on grant.
- SEARCH→RAM on a permitted read or write hit.
- SEARCH→COMPACT on a free of a row that is not last.
- SEARCH→DELAY on a miss, a refusal, a reserve, a release or a free of the last row.
- SEARCH→SEARCH while scanning.
- RAM→RAMWAIT for a read and RAM→DELAY for a write.
- RAMWAIT→DELAY.
- COMPACT→DELAY after the last move.
- DELAY→RESP when the count is spent.
- RESP→IDLE.

Top module: `vpt_alloc_table`

## Requirements
- R1: After reset `busy` and `rsp_valid` are low and the table is empty, so any access reports status 2. Opcodes: 1 allocate, 2 read, 3 write, 4 free, 5 reserve, 6 release. Status codes: 0 done, 1 no room, 2 no matching region, 3 reserved by another requester.
- R2: The first successful allocation returns virtual pointer 0 in `rsp_vptr`. Each later one returns the previous pointer plus the previous allocated size. Pointers are not reused after a free.
- R3: An allocation whose size is zero, or whose size added to the allocated total exceeds LIMIT (64), reports status 1 and changes nothing. A request that lands exactly on LIMIT succeeds.
- R4: With 16 live regions an allocation reports status 1, even if the size limit is not reached.
- R5: A read or write at any address inside a region reaches RAM word physical base + (address − region base). A read returns the stored word in `rsp_rdata`. Hits return the region base in `rsp_vptr` and its element type in `rsp_type`.
- R6: A read, write, free, reserve or release at an address outside every live region reports status 2 and leaves the table and RAM unchanged.
- R7: A free accepts any address inside a region. It removes that region, keeps all other regions reachable, and returns the region's size to the allocated total.
- R8: A reserve by requester A on a region makes reads, writes, frees, reserves and releases of that region by any other requester report status 3. Requester A keeps full access, and a release by A lifts the lock.
- R9: Raising a latency input by N delays the response of the operations in its class by exactly N cycles.
- R10: A request whose memory-select input differs from SEL_ID (3) reports status 2 and changes nothing.
- R11: During an allocation `phys_req` stays high until `phys_gnt`, and `phys_size` equals the requested size. The granted `phys_base` becomes the region's physical base.
- R12: Every accepted request yields exactly one single-cycle `rsp_valid` pulse. `busy` is high from the cycle after acceptance until the response, and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lat_alloc | input | LAT_W | Extra response cycles for allocations |
| cfg_lat_access | input | LAT_W | Extra response cycles for reads and writes |
| cfg_lat_ctrl | input | LAT_W | Extra response cycles for free, reserve, release |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 3 | Opcode |
| req_sel | input | SEL_W | Memory-select address |
| req_id | input | ID_W | Requester identity |
| req_size | input | SIZE_W | Allocation size in words |
| req_type | input | TYPE_W | Element type of an allocation |
| req_vptr | input | VP_W | Virtual address for table operations |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 2 | Completion status |
| rsp_vptr | output | VP_W | New pointer or hit region base |
| rsp_type | output | TYPE_W | Element type of hit region |
| rsp_rdata | output | DATA_W | Read data |
| phys_req | output | 1 | Physical base request |
| phys_size | output | SIZE_W | Size asked of the address source |
| phys_gnt | input | 1 | Address source grant |
| phys_base | input | PA_W | Granted physical base |
| ram_en | output | 1 | RAM cycle enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | PA_W | RAM word address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, one cycle after the enable |

## Verification
A corrupted row or a bad compaction shows up at the ports at the next access to the affected region. That access either reports status 2 where the model expects a hit, or a read returns another region's word. A drift in the usage total or in the pointer accumulator shows up at the next allocation, as a wrong `rsp_vptr` or a wrong status 1 or 0. The bench keeps its own queue model of the regions and of RAM. It compares every response field and watches every clock for a stray response pulse, so a fault surfaces within one request of the operation that caused it.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ALLOC = 3'd1,
        OP_READ  = 3'd2,
        OP_WRITE = 3'd3,
        OP_FREE  = 3'd4,
        OP_RESV  = 3'd5,
        OP_REL   = 3'd6,
        OP_SPARE = 3'd7
    } vpt_op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_NOROOM  = 2'd1,
        ST_NOMATCH = 2'd2,
        ST_LOCKED  = 2'd3
    } vpt_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GRANT,
        S_SEARCH,
        S_RAM,
        S_RAMWAIT,
        S_COMPACT,
        S_DELAY,
        S_RESP
    } vpt_state_e;

endpackage

// File: rtl/vpt_range_hit.sv
module vpt_range_hit #(
    parameter int VP_W   = 16,
    parameter int SIZE_W = 8
) (
    input  logic [VP_W-1:0]   base,
    input  logic [SIZE_W-1:0] dim,
    input  logic [VP_W-1:0]   addr,
    output logic              hit,
    output logic [SIZE_W-1:0] offset
);
    logic [VP_W:0] upper;

    assign upper  = {1'b0, base} + {{(VP_W+1-SIZE_W){1'b0}}, dim};
    assign hit    = (addr >= base) && ({1'b0, addr} < upper);
    assign offset = SIZE_W'(addr - base);
endmodule

// File: rtl/vpt_lat_ctr.sv
module vpt_lat_ctr #(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] load_val,
    output logic             done
);
    logic [LAT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (cnt_q != '0)     cnt_q <= cnt_q - LAT_W'(1);
    end

    assign done = (cnt_q == '0);

    // R9
    lat_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - LAT_W'(1)));
endmodule

// File: rtl/vpt_alloc_table.sv
module vpt_alloc_table
    import vpt_pkg::*;
#(
    parameter int              DEPTH  = 16,
    parameter int              VP_W   = 16,
    parameter int              PA_W   = 8,
    parameter int              DATA_W = 32,
    parameter int              SIZE_W = 8,
    parameter int              TYPE_W = 2,
    parameter int              ID_W   = 2,
    parameter int              LAT_W  = 4,
    parameter int              SEL_W  = 4,
    parameter logic [SEL_W-1:0] SEL_ID = 3,
    parameter int              LIMIT  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAT_W-1:0]  cfg_lat_alloc,
    input  logic [LAT_W-1:0]  cfg_lat_access,
    input  logic [LAT_W-1:0]  cfg_lat_ctrl,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [ID_W-1:0]   req_id,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [TYPE_W-1:0] req_type,
    input  logic [VP_W-1:0]   req_vptr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [VP_W-1:0]   rsp_vptr,
    output logic [TYPE_W-1:0] rsp_type,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              phys_req,
    output logic [SIZE_W-1:0] phys_size,
    input  logic              phys_gnt,
    input  logic [PA_W-1:0]   phys_base,
    output logic              ram_en,
    output logic              ram_we,
    output logic [PA_W-1:0]   ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [VP_W:0]    LIMIT_W  = (VP_W+1)'(LIMIT);

    vpt_state_e state_q, state_d;

    vpt_op_e           op_q;
    logic [ID_W-1:0]   id_q;
    logic [SIZE_W-1:0] size_q;
    logic [TYPE_W-1:0] type_q;
    logic [VP_W-1:0]   vptr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [CNT_W-1:0]  idx_q, cnt_q;
    logic [VP_W-1:0]   used_q, next_vp_q;
    vpt_status_e       status_q;
    logic [VP_W-1:0]   rvptr_q;
    logic [DATA_W-1:0] rdata_q;
    logic [TYPE_W-1:0] rtype_q;
    logic [PA_W-1:0]   ram_addr_q;

    logic [VP_W-1:0]   tbl_vp   [DEPTH];
    logic [PA_W-1:0]   tbl_pp   [DEPTH];
    logic [TYPE_W-1:0] tbl_type [DEPTH];
    logic [SIZE_W-1:0] tbl_dim  [DEPTH];
    logic              tbl_res  [DEPTH];
    logic [ID_W-1:0]   tbl_own  [DEPTH];

    vpt_op_e           req_op_e, op_cls;
    logic              sel_ok, op_known, room_ok;
    logic [VP_W:0]     new_total;
    logic [IDX_W-1:0]  cur_i, nxt_i, app_i;
    logic              at_end, last_ent, compact_last, locked;
    logic              e_hit;
    logic [SIZE_W-1:0] e_off;
    logic              lat_load, lat_done;
    logic [LAT_W-1:0]  lat_val;

    assign req_op_e     = vpt_op_e'(req_op);
    assign sel_ok       = (req_sel == SEL_ID);
    assign op_known     = (req_op != 3'd0) && (req_op != 3'd7);
    assign new_total    = {1'b0, used_q} + (VP_W+1)'(req_size);
    assign room_ok      = (cnt_q != FULL_CNT) && (req_size != '0) && (new_total <= LIMIT_W);
    assign cur_i        = idx_q[IDX_W-1:0];
    assign nxt_i        = cur_i + IDX_W'(1);
    assign app_i        = cnt_q[IDX_W-1:0];
    assign at_end       = (idx_q == cnt_q);
    assign last_ent     = (idx_q == cnt_q - CNT_W'(1));
    assign compact_last = (idx_q == cnt_q - CNT_W'(2));
    assign locked       = tbl_res[cur_i] && (tbl_own[cur_i] != id_q);

    vpt_range_hit #(.VP_W(VP_W), .SIZE_W(SIZE_W)) u_hit (
        .base   (tbl_vp[cur_i]),
        .dim    (tbl_dim[cur_i]),
        .addr   (vptr_q),
        .hit    (e_hit),
        .offset (e_off)
    );

    assign op_cls = (state_q == S_IDLE) ? req_op_e : op_q;
    always_comb begin
        unique case (op_cls)
            OP_ALLOC:          lat_val = cfg_lat_alloc;
            OP_READ, OP_WRITE: lat_val = cfg_lat_access;
            default:           lat_val = cfg_lat_ctrl;
        endcase
    end
    assign lat_load = (state_d == S_DELAY) && (state_q != S_DELAY);

    vpt_lat_ctr #(.LAT_W(LAT_W)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lat_load),
        .load_val (lat_val),
        .done     (lat_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid) begin
                if (!sel_ok || !op_known)  state_d = S_DELAY;
                else if (req_op_e == OP_ALLOC) state_d = room_ok ? S_GRANT : S_DELAY;
                else                       state_d = S_SEARCH;
            end
            S_GRANT:   if (phys_gnt) state_d = S_DELAY;
            S_SEARCH: begin
                if (at_end) state_d = S_DELAY;
                else if (e_hit) begin
                    if (locked) state_d = S_DELAY;
                    else begin
                        unique case (op_q)
                            OP_READ, OP_WRITE: state_d = S_RAM;
                            OP_FREE:           state_d = last_ent ? S_DELAY : S_COMPACT;
                            default:           state_d = S_DELAY;
                        endcase
                    end
                end
            end
            S_RAM:     state_d = (op_q == OP_READ) ? S_RAMWAIT : S_DELAY;
            S_RAMWAIT: state_d = S_DELAY;
            S_COMPACT: if (compact_last) state_d = S_DELAY;
            S_DELAY:   if (lat_done) state_d = S_RESP;
            S_RESP:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        rsp_valid  = (state_q == S_RESP);
        rsp_status = status_q;
        rsp_vptr   = rvptr_q;
        rsp_type   = rtype_q;
        rsp_rdata  = rdata_q;
        phys_req   = (state_q == S_GRANT);
        phys_size  = size_q;
        ram_en     = (state_q == S_RAM);
        ram_we     = (state_q == S_RAM) && (op_q == OP_WRITE);
        ram_addr   = ram_addr_q;
        ram_wdata  = wdata_q;
    end

    // table and request datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_NONE; id_q <= '0; size_q <= '0; type_q <= '0;
            vptr_q <= '0; wdata_q <= '0; idx_q <= '0; cnt_q <= '0;
            used_q <= '0; next_vp_q <= '0; status_q <= ST_OK;
            rvptr_q <= '0; rdata_q <= '0; rtype_q <= '0; ram_addr_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tbl_vp[i] <= '0; tbl_pp[i] <= '0; tbl_type[i] <= '0;
                tbl_dim[i] <= '0; tbl_res[i] <= 1'b0; tbl_own[i] <= '0;
            end
        end else begin
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    op_q <= req_op_e; id_q <= req_id; size_q <= req_size;
                    type_q <= req_type; vptr_q <= req_vptr; wdata_q <= req_wdata;
                    idx_q <= '0; rvptr_q <= '0; rdata_q <= '0; rtype_q <= '0;
                    if (!sel_ok || !op_known)                  status_q <= ST_NOMATCH;
                    else if (req_op_e == OP_ALLOC && !room_ok) status_q <= ST_NOROOM;
                    else                                       status_q <= ST_OK;
                end
                S_GRANT: if (phys_gnt) begin
                    tbl_vp[app_i]   <= next_vp_q;
                    tbl_pp[app_i]   <= phys_base;
                    tbl_type[app_i] <= type_q;
                    tbl_dim[app_i]  <= size_q;
                    tbl_res[app_i]  <= 1'b0;
                    tbl_own[app_i]  <= '0;
                    cnt_q     <= cnt_q + CNT_W'(1);
                    used_q    <= used_q + VP_W'(size_q);
                    next_vp_q <= next_vp_q + VP_W'(size_q);
                    rvptr_q   <= next_vp_q;
                end
                S_SEARCH: begin
                    if (at_end) status_q <= ST_NOMATCH;
                    else if (e_hit) begin
                        if (locked) status_q <= ST_LOCKED;
                        else begin
                            rvptr_q    <= tbl_vp[cur_i];
                            rtype_q    <= tbl_type[cur_i];
                            ram_addr_q <= tbl_pp[cur_i] + PA_W'(e_off);
                            unique case (op_q)
                                OP_FREE: begin
                                    used_q <= used_q - VP_W'(tbl_dim[cur_i]);
                                    if (last_ent) cnt_q <= cnt_q - CNT_W'(1);
                                end
                                OP_RESV: begin
                                    tbl_res[cur_i] <= 1'b1;
                                    tbl_own[cur_i] <= id_q;
                                end
                                OP_REL:  tbl_res[cur_i] <= 1'b0;
                                default: ;
                            endcase
                        end
                    end else idx_q <= idx_q + CNT_W'(1);
                end
                S_RAMWAIT: rdata_q <= ram_rdata;
                S_COMPACT: begin
                    tbl_vp[cur_i]   <= tbl_vp[nxt_i];
                    tbl_pp[cur_i]   <= tbl_pp[nxt_i];
                    tbl_type[cur_i] <= tbl_type[nxt_i];
                    tbl_dim[cur_i]  <= tbl_dim[nxt_i];
                    tbl_res[cur_i]  <= tbl_res[nxt_i];
                    tbl_own[cur_i]  <= tbl_own[nxt_i];
                    idx_q <= idx_q + CNT_W'(1);
                    if (compact_last) cnt_q <= cnt_q - CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

    // R3
    used_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, used_q} <= LIMIT_W);

    // R11
    gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phys_req && !phys_gnt) |=> phys_req);

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)) ||
        (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R12
    resp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !busy);
endmodule

// File: tb/vpt_alloc_table_tb.sv
`timescale 1ns/1ps
module vpt_alloc_table_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_lat_alloc = 4'd2, cfg_lat_access = 4'd1, cfg_lat_ctrl = 4'd3;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [3:0]  req_sel = '0;
    logic [1:0]  req_id = '0;
    logic [7:0]  req_size = '0;
    logic [1:0]  req_type = '0;
    logic [15:0] req_vptr = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, rsp_valid;
    logic [1:0]  rsp_status;
    logic [15:0] rsp_vptr;
    logic [1:0]  rsp_type;
    logic [31:0] rsp_rdata;
    logic        phys_req;
    logic [7:0]  phys_size;
    logic        phys_gnt = 1'b0;
    logic [7:0]  phys_base = '0;
    logic        ram_en, ram_we;
    logic [7:0]  ram_addr;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata = '0;

    always #2.5 clk = ~clk;

    vpt_alloc_table dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_lat_alloc(cfg_lat_alloc), .cfg_lat_access(cfg_lat_access), .cfg_lat_ctrl(cfg_lat_ctrl),
        .req_valid(req_valid), .req_op(req_op), .req_sel(req_sel), .req_id(req_id),
        .req_size(req_size), .req_type(req_type), .req_vptr(req_vptr), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_vptr(rsp_vptr),
        .rsp_type(rsp_type), .rsp_rdata(rsp_rdata),
        .phys_req(phys_req), .phys_size(phys_size), .phys_gnt(phys_gnt), .phys_base(phys_base),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic outstanding = 1'b0;
    int exp_size = 0;
    int bump = 0, gwait = 0;

    // reference model of regions and of RAM contents
    int m_vp[$], m_dim[$], m_pp[$], m_type[$], m_res[$], m_own[$];
    int m_used = 0, m_next = 0;
    logic [31:0] mem_model [256];
    logic [31:0] ram [256];

    initial for (int i = 0; i < 256; i++) begin ram[i] = '0; mem_model[i] = '0; end

    always @(posedge clk) if (ram_en) begin
        if (ram_we) ram[ram_addr] <= ram_wdata;
        else        ram_rdata <= ram[ram_addr];
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // backing-address source: grants two cycles after the request
    always @(negedge clk) begin
        if (phys_gnt) begin
            phys_gnt = 1'b0;
            bump += int'(phys_size);
        end else if (phys_req) begin
            gwait++;
            if (gwait == 2) begin
                gwait = 0;
                check("R11 phys_size", 64'(phys_size), 64'(exp_size));
                phys_base = 8'(bump);
                phys_gnt  = 1'b1;
            end
        end
    end

    // per-clock monitor: no response without a request in flight (R12)
    always @(negedge clk) if (rst_n && rsp_valid && !outstanding) begin
        n_chk++; n_fail++;
        $display("FAIL R12 stray response: actual 1 expected 0");
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            finish_run();
        end
    end

    function automatic int find(int vp);
        for (int i = 0; i < m_vp.size(); i++)
            if (vp >= m_vp[i] && vp < m_vp[i] + m_dim[i]) return i;
        return -1;
    endfunction

    task automatic run(int op, int id, int size, int typ, int vp, logic [31:0] wd, int sel,
                       output int st, output int rv, output int rt, output logic [31:0] rd,
                       output int lat);
        @(negedge clk);
        while (busy) @(negedge clk);
        req_op = op[2:0]; req_id = id[1:0]; req_size = size[7:0]; req_type = typ[1:0];
        req_vptr = vp[15:0]; req_wdata = wd; req_sel = sel[3:0];
        exp_size = size; outstanding = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; lat = 1;
        check("R12 busy after accept", 64'(busy), 64'd1);
        while (!rsp_valid) begin @(negedge clk); lat++; end
        st = int'(rsp_status); rv = int'(rsp_vptr); rt = int'(rsp_type); rd = rsp_rdata;
        @(negedge clk);
        check("R12 single pulse", 64'(rsp_valid), 64'd0);
        check("R12 idle after response", 64'(busy), 64'd0);
        outstanding = 1'b0;
    endtask

    task automatic issue(string tag, int op, int id, int size, int typ, int vp,
                         logic [31:0] wd, int sel, output int lat);
        int k, off, est, erv, ert, epp, st, rv, rt;
        logic [31:0] erd, rd;
        est = 0; erv = 0; ert = 0; erd = '0; k = -1; off = 0;
        if (sel != 3 || op < 1 || op > 6) est = 2;
        else if (op == 1) begin
            if (m_vp.size() == 16 || size == 0 || m_used + size > 64) est = 1;
            else erv = m_next;
        end else begin
            k = find(vp);
            if (k < 0) est = 2;
            else if (m_res[k] != 0 && m_own[k] != id) est = 3;
            else begin
                erv = m_vp[k]; ert = m_type[k]; off = vp - m_vp[k];
                if (op == 2) erd = mem_model[m_pp[k] + off];
            end
        end
        epp = bump;
        run(op, id, size, typ, vp, wd, sel, st, rv, rt, rd, lat);
        check({tag, " status"}, 64'(st), 64'(est));
        check({tag, " vptr"},   64'(rv), 64'(erv));
        check({tag, " type"},   64'(rt), 64'(ert));
        check({tag, " rdata"},  64'(rd), 64'(erd));
        if (est == 0 && sel == 3) begin
            case (op)
                1: begin
                    m_vp.push_back(erv); m_dim.push_back(size); m_pp.push_back(epp);
                    m_type.push_back(typ); m_res.push_back(0); m_own.push_back(0);
                    m_used += size; m_next += size;
                end
                3: begin
                    mem_model[m_pp[k] + off] = wd;
                    check({tag, " physical word"}, 64'(ram[m_pp[k] + off]), 64'(wd));
                end
                4: begin
                    m_used -= m_dim[k];
                    m_vp.delete(k); m_dim.delete(k); m_pp.delete(k);
                    m_type.delete(k); m_res.delete(k); m_own.delete(k);
                end
                5: begin m_res[k] = 1; m_own[k] = id; end
                6: m_res[k] = 0;
                default: ;
            endcase
        end
    endtask

    initial begin
        int l0, l1, lx;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy at reset", 64'(busy), 64'd0);
        check("R1 rsp_valid at reset", 64'(rsp_valid), 64'd0);
        issue("R1 empty table read", 2, 0, 0, 0, 0, 0, 3, lx);

        // R2 pointer accumulation, R11 bases
        issue("R2 alloc A", 1, 0, 10, 1, 0, 0, 3, lx);
        issue("R2 alloc B", 1, 0, 4, 2, 0, 0, 3, lx);
        issue("R2 alloc C", 1, 0, 6, 3, 0, 0, 3, lx);

        // R5 interior access
        issue("R5 write A", 3, 0, 0, 0, 3, 32'hA0A0_0003, 3, lx);
        issue("R5 write B", 3, 0, 0, 0, 12, 32'hB0B0_000C, 3, lx);
        issue("R5 write C", 3, 0, 0, 0, 15, 32'hC0C0_000F, 3, lx);
        issue("R5 read A", 2, 0, 0, 0, 3, 0, 3, lx);
        issue("R5 read B", 2, 0, 0, 0, 12, 0, 3, lx);

        // R6 misses
        issue("R6 read past end", 2, 0, 0, 0, 20, 0, 3, lx);
        issue("R6 write miss", 3, 0, 0, 0, 25, 32'hDEAD_BEEF, 3, lx);
        issue("R6 free miss", 4, 0, 0, 0, 30, 0, 3, lx);
        issue("R6 reserve miss", 5, 0, 0, 0, 40, 0, 3, lx);
        issue("R6 read C intact", 2, 0, 0, 0, 15, 0, 3, lx);

        // R3 limit
        issue("R3 over limit", 1, 0, 50, 0, 0, 0, 3, lx);
        issue("R3 zero size", 1, 0, 0, 0, 0, 0, 3, lx);
        issue("R3 exact limit", 1, 0, 44, 2, 0, 0, 3, lx);
        issue("R3 one past limit", 1, 0, 1, 0, 0, 0, 3, lx);

        // R7 free with compaction
        issue("R7 free B interior", 4, 0, 0, 0, 11, 0, 3, lx);
        issue("R7 read A after free", 2, 0, 0, 0, 3, 0, 3, lx);
        issue("R7 read C after move", 2, 0, 0, 0, 15, 0, 3, lx);
        issue("R7 freed B gone", 2, 0, 0, 0, 12, 0, 3, lx);
        issue("R7 R2 alloc after free", 1, 0, 4, 1, 0, 0, 3, lx);

        // R8 reservation
        issue("R8 reserve by 1", 5, 1, 0, 0, 0, 0, 3, lx);
        issue("R8 read by 2", 2, 2, 0, 0, 3, 0, 3, lx);
        issue("R8 write by 2", 3, 2, 0, 0, 3, 32'h1111_1111, 3, lx);
        issue("R8 free by 2", 4, 2, 0, 0, 5, 0, 3, lx);
        issue("R8 reserve by 2", 5, 2, 0, 0, 0, 0, 3, lx);
        issue("R8 release by 2", 6, 2, 0, 0, 0, 0, 3, lx);
        issue("R8 read by owner", 2, 1, 0, 0, 3, 0, 3, lx);
        issue("R8 release by owner", 6, 1, 0, 0, 0, 0, 3, lx);
        issue("R8 read by 2 after release", 2, 2, 0, 0, 3, 0, 3, lx);

        // R10 memory select
        issue("R10 alloc wrong select", 1, 0, 2, 0, 0, 0, 5, lx);
        issue("R10 write wrong select", 3, 0, 0, 0, 3, 32'h2222_2222, 9, lx);
        issue("R10 read A unchanged", 2, 0, 0, 0, 3, 0, 3, lx);

        // R9 latency classes
        cfg_lat_access = 4'd0;
        issue("R9 read lat0", 2, 0, 0, 0, 3, 0, 3, l0);
        cfg_lat_access = 4'd5;
        issue("R9 read lat5", 2, 0, 0, 0, 3, 0, 3, l1);
        check("R9 access delta", 64'(l1 - l0), 64'd5);
        cfg_lat_ctrl = 4'd0;
        issue("R9 reserve lat0", 5, 0, 0, 0, 15, 0, 3, l0);
        cfg_lat_ctrl = 4'd4;
        issue("R9 release lat4", 6, 0, 0, 0, 15, 0, 3, l1);
        check("R9 ctrl delta", 64'(l1 - l0), 64'd4);

        // R4 full table
        issue("R4 free D", 4, 0, 0, 0, 40, 0, 3, lx);
        for (int i = 0; i < 13; i++) issue("R4 fill", 1, 0, 1, i % 4, 0, 0, 3, lx);
        issue("R4 full refused", 1, 0, 1, 0, 0, 0, 3, lx);
        issue("R4 write last", 3, 0, 0, 0, 80, 32'h5A5A_0050, 3, lx);
        issue("R7 free first of full", 4, 0, 0, 0, 0, 0, 3, lx);
        issue("R7 read last after long shift", 2, 0, 0, 0, 80, 0, 3, lx);
        issue("R7 read C after long shift", 2, 0, 0, 0, 15, 0, 3, lx);
        issue("R7 free last entry", 4, 0, 0, 0, 80, 0, 3, lx);
        issue("R2 alloc after last free", 1, 0, 2, 3, 0, 0, 3, lx);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule